// File: doc/BRIEF.md
# Vector Predicated Branch Comparator

This block turns a compare-and-branch into a reduction over a vector of register elements. After a one-cycle `start` pulse it latches the operation's settings and walks the elements one per clock, from index 0 upward. For each element it presents the index on `elem_idx` and takes back a single compare-result bit on `elem_cmp`, in the same cycle. The arithmetic that produces that bit stays outside the block. A mask taken from the predicate of the first source decides which elements count. The branch is taken only if every counted element passes. Each counted element's result bit is also written into a 64-bit result word, which can be returned to the predicate register tied to the second source.

When neither source is flagged as a vector, the block falls back to an ordinary scalar branch. It takes the decision straight from `scalar_cmp` and does not loop. When the run ends, `done` rises and the decision and result word are held until the next `start`. A new `start` is accepted in any state and restarts the operation.

Top module: `vbr_branch_cmp`

## Requirements
- R1: While `rst` is high, and after it falls until the first `start`, the outputs `done`, `taken`, `pred_wr` and `elem_valid` are 0 and `pred_out` is all zeros.
- R2: If `src1_vec` and `src2_vec` are both 0 when `start` is sampled, `done` is 1 in the cycle after that edge. In that case `taken` equals `scalar_cmp`, `pred_wr` is 0, `elem_valid` never rises, and `pred_out` shows the starting word defined in R6.
- R3: If either vector flag is 1 and the effective length N is greater than 0, `elem_valid` is high for exactly N consecutive cycles, starting in the cycle after the start edge. During those cycles `elem_idx` counts 0, 1, …, N-1, and `done` is 1 in the cycle after the last element.
- R4: In vector mode, `taken` is 1 only if `elem_cmp` was 1 for every element whose bit i of `src_mask` is set (bit 0 corresponds to element 0).
- R5: An element whose mask bit is 0 does not affect `taken`, and its bit in `pred_out` keeps its starting value.
- R6: The starting result word is all zeros when `zeroing` is 1 or `dst_pred_en` is 0. Otherwise it is `dst_pred_in`. Bits at index N and above are never changed.
- R7: For each element i whose mask bit is set, bit i of the final `pred_out` equals the `elem_cmp` value returned for element i.
- R8: `pred_wr` is 1 exactly while `done` is 1 for an operation that was in vector mode with `dst_pred_en` = 1. Otherwise it is 0.
- R9: In vector mode, if no element is counted (mask zero over the length, or `vec_len` = 0), the branch is taken. With `vec_len` = 0, `done` is 1 in the cycle after the start edge.
- R10: Once `done` is 1, `done`, `taken` and `pred_out` stay unchanged until the next `start` is sampled.
- R11: A `vec_len` larger than `MAX_VL` is treated as `MAX_VL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins an operation |
| vec_len | input | LEN_W (7) | Requested vector length |
| src1_vec | input | 1 | First source is a vector |
| src2_vec | input | 1 | Second source is a vector |
| src_mask | input | 64 | Element enable mask from the first source's predicate |
| zeroing | input | 1 | Start the result word from zero |
| dst_pred_en | input | 1 | Second source has a destination predicate register |
| dst_pred_in | input | 64 | Current value of that destination predicate |
| scalar_cmp | input | 1 | Compare result used in scalar mode |
| elem_cmp | input | 1 | Compare result for the element on `elem_idx` |
| elem_valid | output | 1 | An element is being evaluated this cycle |
| elem_idx | output | IDX_W (6) | Index of the element being evaluated |
| done | output | 1 | Operation finished; results valid |
| taken | output | 1 | Branch decision |
| pred_out | output | 64 | Result predicate word |
| pred_wr | output | 1 | Result word is to be written back |

## Verification
The scalar fallback is exercised with both compare outcomes while `elem_cmp` toggles, which shows that the vector path is bypassed. Vector runs use several combinations of compare results and masks: all passing, one counted failure, and a failure on a masked-off element. Together these separate a reduction that honours the mask from one that ignores it. Runs with zeroing on, with no destination predicate and with a loaded destination predicate cover each rule for the starting word, including bits beyond the length. Zero-length runs, empty-mask runs, a full 64-element run that fails on its last element, and an oversized length probe the edges of the index counter.

// File: rtl/vbr_pkg.sv
package vbr_pkg;

    localparam int unsigned PRED_W = 64;

    typedef logic [PRED_W-1:0] pred_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } vbr_state_e;

    typedef struct packed {
        logic vector_mode;
        logic dst_wr;
    } op_flags_t;

    // Starting value of the result word for a new operation.
    function automatic pred_t seed_word(input logic zero_mode,
                                        input logic dst_present,
                                        input pred_t current);
        return (zero_mode || !dst_present) ? '0 : current;
    endfunction

endpackage

// File: rtl/vbr_ctrl.sv
module vbr_ctrl
    import vbr_pkg::*;
#(
    parameter int unsigned MAX_VL = 64,
    parameter int unsigned LEN_W  = $clog2(MAX_VL + 1),
    parameter int unsigned IDX_W  = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             vector_mode,
    input  logic [LEN_W-1:0] vec_len,
    output vbr_state_e       state_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             step_o,
    output logic             last_o
);

    logic [LEN_W-1:0] len_eff;
    logic [IDX_W-1:0] last_idx;
    logic [IDX_W-1:0] lim_q;
    logic [IDX_W-1:0] idx_q;
    vbr_state_e       state_q;

    always_comb begin
        len_eff  = (vec_len > LEN_W'(MAX_VL)) ? LEN_W'(MAX_VL) : vec_len;
        last_idx = IDX_W'(len_eff - LEN_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            lim_q   <= '0;
        end else if (start) begin
            idx_q   <= '0;
            lim_q   <= last_idx;
            state_q <= (vector_mode && (len_eff != '0)) ? ST_RUN : ST_DONE;
        end else if (state_q == ST_RUN) begin
            if (idx_q == lim_q) begin
                state_q <= ST_DONE;
            end else begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    assign state_o = state_q;
    assign idx_o   = idx_q;
    assign step_o  = (state_q == ST_RUN);
    assign last_o  = (state_q == ST_RUN) && (idx_q == lim_q);

    // R3: indices advance by one each cycle while a run continues
    p_idx_advance_r3: assert property (@(posedge clk) disable iff (rst)
        (step_o && !last_o && !start) |=> (step_o && idx_o == $past(idx_o) + IDX_W'(1)));

    // R3: the last element hands over to the finished state
    p_last_to_done_r3: assert property (@(posedge clk) disable iff (rst)
        (last_o && !start) |=> (state_o == ST_DONE));

    // R2: scalar operations finish without looping
    p_scalar_direct_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !vector_mode) |=> (state_o == ST_DONE));

    // R10: the finished state persists until a new start
    p_done_persist_r10: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_DONE && !start) |=> (state_o == ST_DONE));

endmodule

// File: rtl/vbr_accum.sv
module vbr_accum
    import vbr_pkg::*;
#(
    parameter int unsigned IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  pred_t            seed,
    input  pred_t            mask_in,
    input  logic             vector_mode,
    input  logic             scalar_cmp,
    input  logic             step,
    input  logic [IDX_W-1:0] idx,
    input  logic             elem_cmp,
    output pred_t            word_o,
    output logic             pass_o
);

    pred_t mask_q;
    pred_t word_q;
    logic  pass_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            word_q <= '0;
            pass_q <= 1'b0;
        end else if (start) begin
            mask_q <= mask_in;
            word_q <= seed;
            pass_q <= vector_mode ? 1'b1 : scalar_cmp;
        end else if (step && mask_q[idx]) begin
            word_q[idx] <= elem_cmp;
            if (!elem_cmp) begin
                pass_q <= 1'b0;
            end
        end
    end

    assign word_o = word_q;
    assign pass_o = pass_q;

    // R4: a counted failing element clears the pass flag
    p_fail_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (step && !start && mask_q[idx] && !elem_cmp) |=> !pass_o);

    // R5: a masked-off element changes neither the word nor the flag
    p_masked_inert_r5: assert property (@(posedge clk) disable iff (rst)
        (step && !start && !mask_q[idx]) |=> ($stable(word_o) && $stable(pass_o)));

    // R7: a counted element's compare result lands in its own bit
    p_bit_written_r7: assert property (@(posedge clk) disable iff (rst)
        (step && !start && mask_q[idx]) |=> (word_o[$past(idx)] == $past(elem_cmp)));

endmodule

// File: rtl/vbr_branch_cmp.sv
module vbr_branch_cmp
    import vbr_pkg::*;
#(
    parameter int unsigned MAX_VL = 64,
    parameter int unsigned LEN_W  = $clog2(MAX_VL + 1),
    parameter int unsigned IDX_W  = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [LEN_W-1:0]     vec_len,
    input  logic                 src1_vec,
    input  logic                 src2_vec,
    input  logic [PRED_W-1:0]    src_mask,
    input  logic                 zeroing,
    input  logic                 dst_pred_en,
    input  logic [PRED_W-1:0]    dst_pred_in,
    input  logic                 scalar_cmp,
    input  logic                 elem_cmp,
    output logic                 elem_valid,
    output logic [IDX_W-1:0]     elem_idx,
    output logic                 done,
    output logic                 taken,
    output logic [PRED_W-1:0]    pred_out,
    output logic                 pred_wr
);

    op_flags_t  flags_d;
    op_flags_t  flags_q;
    vbr_state_e state;
    logic [IDX_W-1:0] idx;
    logic       step;
    logic       last;
    pred_t      word;
    logic       pass;

    always_comb begin
        flags_d.vector_mode = src1_vec | src2_vec;
        flags_d.dst_wr      = (src1_vec | src2_vec) & dst_pred_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else if (start) begin
            flags_q <= flags_d;
        end
    end

    vbr_ctrl #(
        .MAX_VL (MAX_VL),
        .LEN_W  (LEN_W),
        .IDX_W  (IDX_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .vector_mode (flags_d.vector_mode),
        .vec_len     (vec_len),
        .state_o     (state),
        .idx_o       (idx),
        .step_o      (step),
        .last_o      (last)
    );

    vbr_accum #(
        .IDX_W (IDX_W)
    ) u_accum (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .seed        (seed_word(zeroing, dst_pred_en, dst_pred_in)),
        .mask_in     (src_mask),
        .vector_mode (flags_d.vector_mode),
        .scalar_cmp  (scalar_cmp),
        .step        (step),
        .idx         (idx),
        .elem_cmp    (elem_cmp),
        .word_o      (word),
        .pass_o      (pass)
    );

    assign elem_valid = step;
    assign elem_idx   = idx;
    assign done       = (state == ST_DONE);
    assign taken      = (state == ST_DONE) && pass;
    assign pred_out   = word;
    assign pred_wr    = (state == ST_DONE) && flags_q.dst_wr;

    // R2: scalar start yields a finished result with no writeback next cycle
    p_scalar_result_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !src1_vec && !src2_vec) |=> (done && !pred_wr && !elem_valid));

    // R9: zero-length vector operation is taken at once
    p_empty_taken_r9: assert property (@(posedge clk) disable iff (rst)
        (start && (src1_vec || src2_vec) && vec_len == '0) |=> (done && taken));

    // R10: results hold while finished and no new start arrives
    p_results_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(taken) && $stable(pred_out) && $stable(pred_wr)));

    // R3: the last element is the one immediately before completion
    p_last_then_done_r3: assert property (@(posedge clk) disable iff (rst)
        (last && !start) |=> (done && !elem_valid));

endmodule

// File: tb/vbr_branch_cmp_tb.sv
module vbr_branch_cmp_tb;

    localparam int MAX_VL = 64;
    localparam int LEN_W  = 7;
    localparam int IDX_W  = 6;

    typedef struct {
        int          nelem;
        bit          taken;
        logic [63:0] pred;
        bit          wr;
        string       ttag;
        string       ptag;
    } exp_item_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [LEN_W-1:0]  vec_len = '0;
    logic              src1_vec = 1'b0;
    logic              src2_vec = 1'b0;
    logic [63:0]       src_mask = '0;
    logic              zeroing = 1'b0;
    logic              dst_pred_en = 1'b0;
    logic [63:0]       dst_pred_in = '0;
    logic              scalar_cmp = 1'b0;
    logic [63:0]       cmp_vec = '0;
    logic              elem_cmp;
    logic              elem_valid;
    logic [IDX_W-1:0]  elem_idx;
    logic              done;
    logic              taken;
    logic [63:0]       pred_out;
    logic              pred_wr;

    int n_checks = 0;
    int n_errors = 0;

    exp_item_t q[$];
    exp_item_t cur;
    exp_item_t last_item;
    bit  active = 0;
    bit  have_last = 0;
    int  k = 0;
    int  seq_bad = 0;
    int  hold_seen = 0;
    int  hold_bad = 0;

    always #5 clk = ~clk;

    assign elem_cmp = cmp_vec[elem_idx];

    vbr_branch_cmp #(.MAX_VL(MAX_VL)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .vec_len     (vec_len),
        .src1_vec    (src1_vec),
        .src2_vec    (src2_vec),
        .src_mask    (src_mask),
        .zeroing     (zeroing),
        .dst_pred_en (dst_pred_en),
        .dst_pred_in (dst_pred_in),
        .scalar_cmp  (scalar_cmp),
        .elem_cmp    (elem_cmp),
        .elem_valid  (elem_valid),
        .elem_idx    (elem_idx),
        .done        (done),
        .taken       (taken),
        .pred_out    (pred_out),
        .pred_wr     (pred_wr)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: follows each operation cycle by cycle and compares at completion
    always @(negedge clk) begin
        if (!rst) begin
            if (start && !active) begin
                if (have_last && hold_seen > 0)
                    check(hold_bad == 0, "R10", "results held while idle",
                          64'(hold_bad), 64'd0);
                hold_seen = 0;
                hold_bad  = 0;
                active    = 1;
                k         = 0;
                seq_bad   = 0;
            end else if (active) begin
                k++;
                cur = q[0];
                if (k <= cur.nelem) begin
                    if (elem_valid !== 1'b1 || int'(elem_idx) != k - 1 || done !== 1'b0)
                        seq_bad++;
                end else begin
                    if (elem_valid !== 1'b0) seq_bad++;
                    check(done === 1'b1, (cur.nelem == 0) ? "R2" : "R3",
                          "done at expected cycle", 64'(done), 64'd1);
                    check(seq_bad == 0, (cur.nelem == 0) ? "R2" : "R3",
                          "element sequence", 64'(seq_bad), 64'd0);
                    check(taken === cur.taken, cur.ttag, "taken",
                          64'(taken), 64'(cur.taken));
                    check(pred_out === cur.pred, cur.ptag, "pred_out",
                          pred_out, cur.pred);
                    check(pred_wr === cur.wr, "R8", "pred_wr",
                          64'(pred_wr), 64'(cur.wr));
                    last_item = cur;
                    have_last = 1;
                    void'(q.pop_front());
                    active = 0;
                end
            end else if (have_last) begin
                hold_seen++;
                if (done !== 1'b1 || taken !== last_item.taken || pred_out !== last_item.pred)
                    hold_bad++;
            end
        end
    end

    // Driver: computes the expected outcome and launches one operation
    task automatic run_op(input bit s1, input bit s2, input int vl,
                          input logic [63:0] mask, input logic [63:0] cmpv,
                          input bit zero, input bit den, input logic [63:0] din,
                          input bit scmp, input string ttag, input string ptag);
        exp_item_t it;
        bit vec;
        bit pass;
        int n;
        logic [63:0] w;
        vec  = s1 | s2;
        n    = vec ? ((vl > MAX_VL) ? MAX_VL : vl) : 0;
        w    = (zero || !den) ? 64'd0 : din;
        pass = 1;
        for (int i = 0; i < n; i++) begin
            if (mask[i]) begin
                w[i] = cmpv[i];
                if (!cmpv[i]) pass = 0;
            end
        end
        it.nelem = n;
        it.taken = vec ? pass : scmp;
        it.pred  = w;
        it.wr    = vec && den;
        it.ttag  = ttag;
        it.ptag  = ptag;
        @(posedge clk);
        #1;
        q.push_back(it);
        src1_vec    = s1;
        src2_vec    = s2;
        vec_len     = LEN_W'(vl);
        src_mask    = mask;
        cmp_vec     = cmpv;
        zeroing     = zero;
        dst_pred_en = den;
        dst_pred_in = din;
        scalar_cmp  = scmp;
        start       = 1'b1;
        @(posedge clk);
        #1;
        start = 1'b0;
        wait (q.size() == 0);
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(done === 1'b0 && taken === 1'b0 && pred_wr === 1'b0 && elem_valid === 1'b0,
              "R1", "control outputs in reset", {60'd0, done, taken, pred_wr, elem_valid}, 64'd0);
        check(pred_out === 64'd0, "R1", "pred_out in reset", pred_out, 64'd0);
        @(posedge clk);
        #1;
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(done === 1'b0 && pred_out === 64'd0, "R1", "idle after reset",
              pred_out, 64'd0);

        // R2: scalar fallback, both outcomes, vector inputs present but ignored
        run_op(0, 0, 8, 64'hFF, 64'h00, 0, 1, 64'hA5A5, 1, "R2", "R2");
        run_op(0, 0, 8, 64'hFF, 64'hFF, 0, 1, 64'h1234, 0, "R2", "R2");
        // R4 R7: all counted elements pass
        run_op(1, 0, 8, 64'hFF, 64'hFF, 0, 1, 64'hF0F0_0000_0000_0000, 0, "R4", "R7");
        // R4: one counted element fails
        run_op(1, 1, 8, 64'hFF, 64'hF7, 0, 1, 64'd0, 1, "R4", "R7");
        // R5: masked-off element fails, keeps initial bit; R6 upper bits kept
        run_op(1, 0, 8, 64'hEF, 64'hEF, 0, 1, 64'hDEAD_BEEF_0000_FF10, 0, "R5", "R6");
        // R6: zeroing clears the start word
        run_op(1, 0, 16, 64'h0F0F, 64'h00FF, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R4", "R6");
        // R6 R8: no destination predicate
        run_op(1, 0, 12, 64'hFFF, 64'hABC, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R4", "R6");
        // R9: empty mask over the length
        run_op(1, 0, 5, 64'hFFFF_FFFF_FFFF_FFE0, 64'd0, 0, 1, 64'h55, 0, "R9", "R5");
        // R9: zero length
        run_op(0, 1, 0, 64'hFF, 64'd0, 0, 1, 64'h3C, 0, "R9", "R6");
        // R11: oversized length clamps to the maximum
        run_op(1, 0, 100, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
               0, 1, 64'd0, 0, "R4", "R11");
        // R3 R4: full length, only the last element fails
        run_op(0, 1, 64, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF,
               0, 1, 64'd0, 1, "R4", "R7");
        // R5 R7: sparse mask with mixed results
        run_op(1, 1, 40, 64'h0000_00A5_5A5A_A5A5, 64'h0000_00FF_0F0F_F00F,
               0, 1, 64'h1111_2222_3333_4444, 1, "R5", "R7");

        repeat (3) @(negedge clk);
        if (hold_seen > 0)
            check(hold_bad == 0, "R10", "results held at end", 64'(hold_bad), 64'd0);
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule